// File: doc/BRIEF.md
# Reed-Solomon ECC Register and Handshake Block

This block is the host-side register file that sits in front of a Reed-Solomon error-correction engine protecting 512-byte data blocks with 9 check bytes. Software programs the mode through a control word, loads or collects the check bytes through byte-addressable registers, and learns about engine progress through a sticky status word that can also raise an interrupt.

For a page write, the host enables the engine in encode mode. When the engine reports it is done, the computed check bytes are captured into the parity registers and an encode-complete flag is raised. For a page read, the host selects decode mode, writes the check bytes it read from the spare area, then sets a parity-loaded bit. That rising bit launches the decode. On completion the block records a decode-complete flag, correctable and uncorrectable error flags, and a 3-bit error count held in the top bits of the status word.

The arithmetic engine lies outside this block. It connects through plain level and pulse signals.

Top module: `rs_ecc_regs`

## Requirements
- R1: After reset, the control, status, mask and all parity registers read 0. The outputs irq, eng_enable, eng_clear, eng_rs, eng_encode and eng_start are 0, and par_out is all zeros.
- R2: The control word is at byte address 0x100, with bit 0 enable, bit 1 reset, bit 2 Reed-Solomon select, bit 3 encode (1) or decode (0), and bit 4 parity loaded. A write stores bits 4:0 and they read back. Bits 0, 2 and 3 drive eng_enable, eng_rs and eng_encode. Word registers ignore wr_strb.
- R3: A control write with bit 1 set zeroes all parity bytes at that clock edge. eng_clear and control bit 1 are then high for exactly the following cycle, and drop afterwards unless written again.
- R4: Parity byte i is at byte address 0x108+i. Word 0x108 holds bytes 0..3, word 0x10C holds bytes 4..7, and word 0x110 holds byte 8 in bits 7:0, with bits 31:8 reading 0. Byte lane k is bits 8k+7:8k and is written only when wr_strb[k] is 1. Byte i appears on par_out[8i+7:8i].
- R5: eng_done while enabled in encode mode loads eng_par_in into the parity registers and sets status bit 2 (encode finished).
- R6: A control write that raises bit 4 from 0 to 1 with enable 1 and encode 0 makes eng_start high for exactly the cycle after that write. A write in encode mode, or one that leaves bit 4 at 1, makes no start.
- R7: eng_done while enabled in decode mode sets status bit 3 (decode finished). It also sets bit 0 if eng_err is 1 and bit 1 if eng_uncor is 1, and it loads eng_err_cnt into status bits 31:29.
- R8: eng_pad_done sets status bit 4 (pad finished). Status bits 28:5 always read 0.
- R9: The status word is at 0x114. A write clears each flag bit, and each count bit, whose written value is 0, so writing 0 clears everything. An engine event in the same cycle as the write still sets its flag.
- R10: The mask register is at 0x118 and stores bits 4:0. irq is 1 exactly when some status bit in 4:0 is 1 and the matching mask bit is 1.
- R11: eng_done while enable is 0 is ignored: the status and parity registers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write request |
| wr_addr | input | ADDR_W | Write byte address (word selected by bits above 1:0) |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte lane enables for parity words |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Combinational read data |
| eng_enable | output | 1 | Engine enable level |
| eng_clear | output | 1 | One-cycle engine clear pulse |
| eng_rs | output | 1 | Reed-Solomon select level |
| eng_encode | output | 1 | 1 = encode, 0 = decode |
| eng_start | output | 1 | One-cycle decode start pulse |
| par_out | output | 8*PAR_BYTES | Stored parity bytes to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Decode found errors |
| eng_uncor | input | 1 | Decode errors not correctable |
| eng_err_cnt | input | CNT_W | Number of correctable errors |
| eng_pad_done | input | 1 | Padding finished pulse |
| eng_par_in | input | 8*PAR_BYTES | Parity computed by the engine |
| irq | output | 1 | Masked interrupt |

## Verification
Every register update, and every flag set by an engine pulse, is visible one clock edge after the input cycle. eng_clear and eng_start are high only during the cycle that follows the triggering write. Reads and irq are combinational from the stored state. The bench drives inputs on the falling edge and releases them on the next falling edge, so each result is checked at that second falling edge. For the two pulses it checks once more one cycle later to confirm they have dropped.

// File: rtl/rs_ecc_pkg.sv
package rs_ecc_pkg;
   localparam int unsigned OFS_CTRL = 32'h100;
   localparam int unsigned OFS_PAR  = 32'h108;
   localparam int unsigned OFS_STAT = 32'h114;
   localparam int unsigned OFS_MASK = 32'h118;

   localparam int FLAG_W = 5;
   localparam int SB_ERR = 0;
   localparam int SB_UNC = 1;
   localparam int SB_ENC = 2;
   localparam int SB_DEC = 3;
   localparam int SB_PAD = 4;

   typedef struct packed {
      logic prdy;
      logic enc;
      logic rs;
      logic rst;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/ecc_ctrl_reg.sv
module ecc_ctrl_reg
   import rs_ecc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_hit,
   input  logic [4:0] wr_bits,
   output ctrl_t      ctrl_q,
   output logic       clr_now,
   output logic       start_q
);
   ctrl_t d;
   assign d       = ctrl_t'(wr_bits);
   assign clr_now = wr_hit && d.rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= wr_hit && d.prdy && !ctrl_q.prdy && d.en && !d.enc;
         if (wr_hit) ctrl_q <= d;
         else        ctrl_q.rst <= 1'b0;
      end
   end

   AST_RST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.rst && !wr_hit |=> !ctrl_q.rst); // R3
   AST_START_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q); // R6
   AST_START_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (ctrl_q.en && !ctrl_q.enc && ctrl_q.prdy)); // R6
endmodule

// File: rtl/ecc_parity_bank.sv
module ecc_parity_bank
   import rs_ecc_pkg::*;
#(
   parameter int NBYTES = 9,
   parameter int ADDR_W = 12
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                load,
   input  logic [8*NBYTES-1:0] load_data,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [31:0]         wr_data,
   input  logic [3:0]          wr_strb,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [8*NBYTES-1:0] par_q,
   output logic [31:0]         rd_word,
   output logic                rd_hit
);
   localparam int W0 = OFS_PAR / 4;
   localparam int WA = ADDR_W - 2;

   logic [WA-1:0] wr_w;
   logic [WA-1:0] rd_w;
   assign wr_w = wr_addr[ADDR_W-1:2];
   assign rd_w = rd_addr[ADDR_W-1:2];

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      localparam logic [WA-1:0] MYW = WA'(W0 + i / 4);
      localparam int LANE = i % 4;
      logic       hit;
      logic [7:0] b_q;
      assign hit = wr_en && (wr_w == MYW) && wr_strb[LANE];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    b_q <= '0;
         else if (clr)  b_q <= '0;
         else if (load) b_q <= load_data[8*i +: 8];
         else if (hit)  b_q <= wr_data[8*LANE +: 8];
      end
      assign par_q[8*i +: 8] = b_q;
   end

   always_comb begin
      rd_word = '0;
      rd_hit  = 1'b0;
      for (int i = 0; i < NBYTES; i++) begin
         if (rd_w == WA'(W0 + i / 4)) begin
            rd_hit = 1'b1;
            rd_word[8*(i%4) +: 8] = par_q[8*i +: 8];
         end
      end
   end

   AST_PAR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (par_q == '0)); // R3
   AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load && !clr |=> (par_q == $past(load_data))); // R5
endmodule

// File: rtl/ecc_status_reg.sv
module ecc_status_reg
   import rs_ecc_pkg::*;
#(
   parameter int CNT_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stat,
   input  logic             wr_mask,
   input  logic [31:0]      wr_data,
   input  logic             ev_done,
   input  logic             ev_enc,
   input  logic             ev_err,
   input  logic             ev_unc,
   input  logic [CNT_W-1:0] ev_cnt,
   input  logic             ev_pad,
   output logic [31:0]      stat_word,
   output logic [31:0]      mask_word,
   output logic             irq
);
   logic [FLAG_W-1:0] flags_q, flags_n, mask_q;
   logic [CNT_W-1:0]  cnt_q, cnt_n;

   always_comb begin
      flags_n = flags_q;
      cnt_n   = cnt_q;
      if (wr_stat) begin
         flags_n = flags_q & wr_data[FLAG_W-1:0];
         cnt_n   = cnt_q & wr_data[31 -: CNT_W];
      end
      if (ev_done && ev_enc) flags_n[SB_ENC] = 1'b1;
      if (ev_done && !ev_enc) begin
         flags_n[SB_DEC] = 1'b1;
         if (ev_err) flags_n[SB_ERR] = 1'b1;
         if (ev_unc) flags_n[SB_UNC] = 1'b1;
         cnt_n = ev_cnt;
      end
      if (ev_pad) flags_n[SB_PAD] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         cnt_q   <= '0;
         mask_q  <= '0;
      end else begin
         flags_q <= flags_n;
         cnt_q   <= cnt_n;
         if (wr_mask) mask_q <= wr_data[FLAG_W-1:0];
      end
   end

   always_comb begin
      stat_word = '0;
      stat_word[FLAG_W-1:0] = flags_q;
      stat_word[31 -: CNT_W] = cnt_q;
      mask_word = '0;
      mask_word[FLAG_W-1:0] = mask_q;
   end

   assign irq = |(flags_q & mask_q);

   AST_ENC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done && ev_enc |=> flags_q[SB_ENC]); // R5
   AST_DEC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done && !ev_enc |=> flags_q[SB_DEC] && (cnt_q == $past(ev_cnt))); // R7
   AST_PAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pad |=> flags_q[SB_PAD]); // R8
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq); // R10
endmodule

// File: rtl/rs_ecc_regs.sv
module rs_ecc_regs
   import rs_ecc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int PAR_BYTES = 9,
   parameter int CNT_W     = 3
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [31:0]            wr_data,
   input  logic [3:0]             wr_strb,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [31:0]            rd_data,
   output logic                   eng_enable,
   output logic                   eng_clear,
   output logic                   eng_rs,
   output logic                   eng_encode,
   output logic                   eng_start,
   output logic [8*PAR_BYTES-1:0] par_out,
   input  logic                   eng_done,
   input  logic                   eng_err,
   input  logic                   eng_uncor,
   input  logic [CNT_W-1:0]       eng_err_cnt,
   input  logic                   eng_pad_done,
   input  logic [8*PAR_BYTES-1:0] eng_par_in,
   output logic                   irq
);
   localparam int WA = ADDR_W - 2;
   localparam logic [WA-1:0] W_CTRL = WA'(OFS_CTRL / 4);
   localparam logic [WA-1:0] W_STAT = WA'(OFS_STAT / 4);
   localparam logic [WA-1:0] W_MASK = WA'(OFS_MASK / 4);

   if (PAR_BYTES < 1 || PAR_BYTES > 12) begin : g_bad_par
      $error("PAR_BYTES must fit between the parity base and the status word");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must be 1 to 8");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W too small for the register offsets");
   end

   logic [WA-1:0] wr_w, rd_w;
   assign wr_w = wr_addr[ADDR_W-1:2];
   assign rd_w = rd_addr[ADDR_W-1:2];

   ctrl_t ctrl_q;
   logic  clr_now, start_q;
   logic  ev_done, par_load;
   logic [31:0] stat_word, mask_word, par_word;
   logic        par_hit;

   ecc_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_en && (wr_w == W_CTRL)),
      .wr_bits (wr_data[4:0]),
      .ctrl_q  (ctrl_q),
      .clr_now (clr_now),
      .start_q (start_q)
   );

   assign ev_done  = eng_done && ctrl_q.en;
   assign par_load = ev_done && ctrl_q.enc;

   ecc_parity_bank #(.NBYTES(PAR_BYTES), .ADDR_W(ADDR_W)) u_par (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_now),
      .load      (par_load),
      .load_data (eng_par_in),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_strb   (wr_strb),
      .rd_addr   (rd_addr),
      .par_q     (par_out),
      .rd_word   (par_word),
      .rd_hit    (par_hit)
   );

   ecc_status_reg #(.CNT_W(CNT_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stat   (wr_en && (wr_w == W_STAT)),
      .wr_mask   (wr_en && (wr_w == W_MASK)),
      .wr_data   (wr_data),
      .ev_done   (ev_done),
      .ev_enc    (ctrl_q.enc),
      .ev_err    (eng_err),
      .ev_unc    (eng_uncor),
      .ev_cnt    (eng_err_cnt),
      .ev_pad    (eng_pad_done),
      .stat_word (stat_word),
      .mask_word (mask_word),
      .irq       (irq)
   );

   assign eng_enable = ctrl_q.en;
   assign eng_clear  = ctrl_q.rst;
   assign eng_rs     = ctrl_q.rs;
   assign eng_encode = ctrl_q.enc;
   assign eng_start  = start_q;

   always_comb begin
      rd_data = '0;
      if (rd_w == W_CTRL)      rd_data = {27'b0, ctrl_q};
      else if (rd_w == W_STAT) rd_data = stat_word;
      else if (rd_w == W_MASK) rd_data = mask_word;
      else if (par_hit)        rd_data = par_word;
   end

   AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done && !ctrl_q.en && !wr_en && !eng_pad_done
      |=> $stable(stat_word) && $stable(par_out)); // R11
endmodule

// File: tb/rs_ecc_regs_tb.sv
module rs_ecc_regs_tb;
   localparam int ADDR_W = 12;
   localparam int NB     = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0] wr_strb = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic eng_enable, eng_clear, eng_rs, eng_encode, eng_start, irq;
   logic [8*NB-1:0] par_out;
   logic eng_done = 1'b0, eng_err = 1'b0, eng_uncor = 1'b0, eng_pad_done = 1'b0;
   logic [2:0] eng_err_cnt = '0;
   logic [8*NB-1:0] eng_par_in = '0;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   localparam logic [71:0] ENC_PAT = 72'h1F2E3D4C5B6A798897;
   localparam logic [71:0] OTHER_PAT = 72'hA5A5A5A5A5A5A5A5A5;

   always #4 clk = ~clk;

   rs_ecc_regs #(.ADDR_W(ADDR_W), .PAR_BYTES(NB), .CNT_W(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_strb(wr_strb), .rd_addr(rd_addr),
      .rd_data(rd_data), .eng_enable(eng_enable), .eng_clear(eng_clear),
      .eng_rs(eng_rs), .eng_encode(eng_encode), .eng_start(eng_start),
      .par_out(par_out), .eng_done(eng_done), .eng_err(eng_err),
      .eng_uncor(eng_uncor), .eng_err_cnt(eng_err_cnt),
      .eng_pad_done(eng_pad_done), .eng_par_in(eng_par_in), .irq(irq)
   );

   task automatic check(input string tag, input logic [71:0] got, input logic [71:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
      @(negedge clk);
      wr_en = 1'b0; wr_strb = '0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic pulse_done(input logic e, input logic u, input logic [2:0] c, input logic [71:0] p);
      @(negedge clk);
      eng_done = 1'b1; eng_err = e; eng_uncor = u; eng_err_cnt = c; eng_par_in = p;
      @(negedge clk);
      eng_done = 1'b0; eng_err = 1'b0; eng_uncor = 1'b0; eng_err_cnt = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(12'h100, v); check("R1 ctrl", 72'(v), 72'h0);
      rd(12'h114, v); check("R1 status", 72'(v), 72'h0);
      rd(12'h118, v); check("R1 mask", 72'(v), 72'h0);
      rd(12'h10C, v); check("R1 parity word", 72'(v), 72'h0);
      check("R1 par_out", par_out, 72'h0);
      check("R1 outputs", 72'({irq, eng_enable, eng_clear, eng_rs, eng_encode, eng_start}), 72'h0);
   endtask

   task automatic t_ctrl();
      logic [31:0] v;
      wr(12'h100, 32'h0000_000D, 4'h0);
      rd(12'h100, v); check("R2 ctrl readback", 72'(v), 72'h0D);
      check("R2 levels en/rs/enc", 72'({eng_enable, eng_rs, eng_encode, eng_start}), 72'hE);
   endtask

   task automatic t_parity();
      logic [31:0] v;
      wr(12'h108, 32'h4433_2211, 4'hF);
      wr(12'h10C, 32'h8877_6655, 4'hF);
      wr(12'h110, 32'hAABB_CC99, 4'hF);
      rd(12'h110, v); check("R4 last word upper zero", 72'(v), 72'h99);
      check("R4 par_out order", par_out, 72'h99_8877_6655_4433_2211);
      wr(12'h108, 32'h00EE_0000, 4'b0100);
      rd(12'h108, v); check("R4 lane strobe", 72'(v), 72'h44EE_2211);
   endtask

   task automatic t_reset_bit();
      logic [31:0] v;
      wr(12'h100, 32'h0000_000F, 4'h0);
      check("R3 clear pulse high", 72'(eng_clear), 72'h1);
      check("R3 parity zeroed", par_out, 72'h0);
      rd(12'h100, v); check("R3 reset bit visible", 72'(v), 72'h0F);
      @(negedge clk);
      check("R3 clear pulse low", 72'(eng_clear), 72'h0);
      rd(12'h100, v); check("R3 reset bit self-clears", 72'(v), 72'h0D);
   endtask

   task automatic t_encode();
      logic [31:0] v;
      pulse_done(1'b0, 1'b0, 3'd0, ENC_PAT);
      rd(12'h114, v); check("R5 encode flag", 72'(v), 72'h4);
      check("R5 parity captured", par_out, ENC_PAT);
      wr(12'h114, 32'h0, 4'hF);
      rd(12'h114, v); check("R9 write zero clears", 72'(v), 72'h0);
   endtask

   task automatic t_decode_start();
      wr(12'h100, 32'h05, 4'h0);
      check("R6 no start without parity bit", 72'(eng_start), 72'h0);
      wr(12'h100, 32'h15, 4'h0);
      check("R6 start pulse", 72'(eng_start), 72'h1);
      @(negedge clk);
      check("R6 start drops", 72'(eng_start), 72'h0);
      wr(12'h100, 32'h15, 4'h0);
      check("R6 no start when already set", 72'(eng_start), 72'h0);
      wr(12'h100, 32'h0D, 4'h0);
      wr(12'h100, 32'h1D, 4'h0);
      check("R6 no start in encode mode", 72'(eng_start), 72'h0);
   endtask

   task automatic t_decode_done();
      logic [31:0] v;
      wr(12'h100, 32'h05, 4'h0);
      pulse_done(1'b1, 1'b0, 3'd3, OTHER_PAT);
      rd(12'h114, v); check("R7 decode flags and count", 72'(v), 72'h6000_0009);
      check("R7 decode leaves parity", par_out, ENC_PAT);
      pulse_done(1'b1, 1'b1, 3'd0, OTHER_PAT);
      rd(12'h114, v); check("R7 uncorrectable", 72'(v), 72'h0000_000B);
      wr(12'h114, 32'hFFFF_FFFE, 4'hF);
      rd(12'h114, v); check("R9 per-bit clear", 72'(v), 72'h0000_000A);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 12'h114; wr_data = 32'h0; eng_pad_done = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; eng_pad_done = 1'b0;
      rd(12'h114, v); check("R8 R9 pad set wins over clear", 72'(v), 72'h10);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(12'h118, 32'h08, 4'h0);
      check("R10 irq masked", 72'(irq), 72'h0);
      wr(12'h118, 32'hFFFF_FF10, 4'h0);
      check("R10 irq raised", 72'(irq), 72'h1);
      rd(12'h118, v); check("R10 mask readback", 72'(v), 72'h10);
      wr(12'h114, 32'h0, 4'hF);
      check("R10 irq drops on clear", 72'(irq), 72'h0);
   endtask

   task automatic t_disabled();
      logic [31:0] v;
      wr(12'h100, 32'h08, 4'h0);
      pulse_done(1'b1, 1'b1, 3'd5, OTHER_PAT);
      rd(12'h114, v); check("R11 status unchanged", 72'(v), 72'h0);
      check("R11 parity unchanged", par_out, ENC_PAT);
   endtask

   initial begin
      #20;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_ctrl();
      t_parity();
      t_reset_bit();
      t_encode();
      t_decode_start();
      t_decode_done();
      t_irq();
      t_disabled();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule